// File: doc/BRIEF.md
# Configuration Word Burst Forwarder

This block sits between the register/memory-write path of a host-attached endpoint and the logic that loads a configuration image. A write that carries a configuration word is placed on a wide output bus, together with a burst of single-cycle clock enables. The burst length comes from a clocks-per-write setting. The setting reflects how the image was prepared: a plain image needs one enable per word, an encrypted image that is not compressed needs four, and any compressed image needs eight.

With the wide option, a separate staging register holds the upper half of a 64-bit word. A write to that register loads it without starting a burst. The next low-half write forwards both halves together. While configuration mode is active, a memory write anywhere in the endpoint's memory window is treated as a low-half data write. Writes that arrive during a burst are held off through a ready signal and are never lost. A write accepted in the last cycle of a burst starts its own burst with no idle cycle.

Top module: `cfg_burst_fwd`

## Requirements
- R1: A write with wrSel = 0 (data register), all byte enables set and modeActive high loads wrData into cfgData[31:0] on the clock edge that accepts it. cfgClkEn is high in the cycle after acceptance.
- R2: Each forwarded word produces exactly N consecutive cfgClkEn cycles. N is the value of clkPerWrite sampled when the write is accepted (typically 1, 4 or 8), and a value of 0 gives one cycle.
- R3: A write with any byte enable clear, or with wrSel = 3 (unrelated register), changes neither cfgData nor the upper staging register and produces no cfgClkEn.
- R4: A write with wrSel = 1 (upper data register), all byte enables set and modeActive high produces no cfgClkEn and leaves cfgData unchanged. Its data appears as cfgData[63:32] of every later forwarded word until the register is written again.
- R5: A write with wrSel = 2 (memory window, any address), all byte enables set and modeActive high is forwarded exactly like an R1 write.
- R6: While modeActive is low, no write changes cfgData or the upper staging register, and none produces cfgClkEn.
- R7: busy is high throughout a burst. wrReady is low while more than one burst cycle remains. A write held by wrReady low stays pending and is forwarded once accepted.
- R8: After reset cfgData and the upper staging register are zero, and cfgClkEn and busy are low. wrReady is high.
- R9: A write accepted in the final cycle of a burst starts its burst in the next cycle, so cfgClkEn stays high with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeActive | input | 1 | Configuration mode is active |
| wrValid | input | 1 | Write request present |
| wrReady | output | 1 | Write accepted on this edge when wrValid is high |
| wrSel | input | 2 | Write target: 0 data register, 1 upper data register, 2 memory window, 3 other |
| wrBe | input | 4 | Byte enables of the write |
| wrData | input | 32 | Write data |
| clkPerWrite | input | 8 | Clock enables per forwarded word (0 is treated as 1) |
| cfgData | output | 64 | Word presented to the configuration logic |
| cfgClkEn | output | 1 | Configuration clock enable |
| busy | output | 1 | Clock-enable burst in progress |

## Verification
The bound checker keeps a free-running count of the expected remaining burst cycles and compares cfgClkEn against it on every edge. Every cycle it also checks that a forwarded word appears one edge after acceptance, that rejected, unrelated, upper-half and out-of-mode writes leave the output word unchanged, and that an idle block is always ready. Only the bench scenarios can show the end-to-end results. These include the exact 64-bit word after an upper-half write followed by low-half writes, the staged upper half surviving rejected writes, a stalled write being forwarded after the earlier burst completes, and a mid-burst reset returning the block to idle.

// File: rtl/cfgfwd_pkg.sv
package cfgfwd_pkg;

  typedef enum logic [1:0] {
    SEL_DATA_LO = 2'd0,
    SEL_DATA_HI = 2'd1,
    SEL_MEM_WIN = 2'd2,
    SEL_OTHER   = 2'd3
  } wrSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadLow;   // capture a full word onto the output bus
    logic loadHigh;  // capture the upper staging half
  } ctrlStrobes_t;

endpackage

// File: rtl/cfgfwd_ctrl.sv
module cfgfwd_ctrl
  import cfgfwd_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 8,
  parameter bit WIDE   = 1'b1,
  localparam int BE_W  = WORD_W / 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeActive,
  input  logic             wrValid,
  input  logic [1:0]       wrSel,
  input  logic [BE_W-1:0]  wrBe,
  input  logic [CNT_W-1:0] clkPerWrite,
  output logic             wrReady,
  output logic             busy,
  output logic             cfgClkEn,
  output ctrlStrobes_t     strb
);

  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] burstLen;
  logic             accept;
  logic             eligible;
  wrSel_e           selE;

  assign selE     = wrSel_e'(wrSel);
  // Ready in the last burst cycle so bursts can chain without a gap
  assign wrReady  = (remain <= CNT_W'(1));
  assign accept   = wrValid && wrReady;
  assign eligible = accept && modeActive && (&wrBe);
  assign burstLen = (clkPerWrite == '0) ? CNT_W'(1) : clkPerWrite;

  always_comb begin
    strb          = '0;
    strb.loadLow  = eligible && ((selE == SEL_DATA_LO) || (selE == SEL_MEM_WIN));
    strb.loadHigh = eligible && (selE == SEL_DATA_HI) && WIDE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain <= '0;
    end else if (strb.loadLow) begin
      remain <= burstLen;
    end else if (remain != '0) begin
      remain <= remain - CNT_W'(1);
    end
  end

  assign busy     = (remain != '0);
  assign cfgClkEn = busy;

endmodule

// File: rtl/cfgfwd_datapath.sv
module cfgfwd_datapath
  import cfgfwd_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter bit WIDE   = 1'b1,
  localparam int OUT_W = WIDE ? 2 * WORD_W : WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [WORD_W-1:0] wrData,
  output logic [OUT_W-1:0]  cfgData
);

  generate
    if (WIDE) begin : gWide
      logic [WORD_W-1:0] upperReg;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          upperReg <= '0;
        end else if (strb.loadHigh) begin
          upperReg <= wrData;
        end
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          cfgData <= '0;
        end else if (strb.loadLow) begin
          cfgData <= {upperReg, wrData};
        end
      end
    end else begin : gNarrow
      logic unusedHigh;
      assign unusedHigh = strb.loadHigh;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          cfgData <= '0;
        end else if (strb.loadLow) begin
          cfgData <= wrData;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/cfg_burst_fwd.sv
module cfg_burst_fwd
  import cfgfwd_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 8,
  parameter bit WIDE   = 1'b1,
  localparam int BE_W  = WORD_W / 8,
  localparam int OUT_W = WIDE ? 2 * WORD_W : WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeActive,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic [1:0]        wrSel,
  input  logic [BE_W-1:0]   wrBe,
  input  logic [WORD_W-1:0] wrData,
  input  logic [CNT_W-1:0]  clkPerWrite,
  output logic [OUT_W-1:0]  cfgData,
  output logic              cfgClkEn,
  output logic              busy
);

  ctrlStrobes_t strb;

  cfgfwd_ctrl #(.WORD_W(WORD_W), .CNT_W(CNT_W), .WIDE(WIDE)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeActive (modeActive),
    .wrValid    (wrValid),
    .wrSel      (wrSel),
    .wrBe       (wrBe),
    .clkPerWrite(clkPerWrite),
    .wrReady    (wrReady),
    .busy       (busy),
    .cfgClkEn   (cfgClkEn),
    .strb       (strb)
  );

  cfgfwd_datapath #(.WORD_W(WORD_W), .WIDE(WIDE)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .cfgData(cfgData)
  );

endmodule

// File: rtl/cfg_burst_fwd_chk.sv
module cfg_burst_fwd_chk #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 8,
  parameter int BE_W   = 4,
  parameter int OUT_W  = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              modeActive,
  input logic              wrValid,
  input logic              wrReady,
  input logic [1:0]        wrSel,
  input logic [BE_W-1:0]   wrBe,
  input logic [WORD_W-1:0] wrData,
  input logic [CNT_W-1:0]  clkPerWrite,
  input logic [OUT_W-1:0]  cfgData,
  input logic              cfgClkEn,
  input logic              busy
);

  logic             acc;
  logic             fwdLow;
  logic [CNT_W-1:0] expRem;

  assign acc    = wrValid && wrReady;
  assign fwdLow = acc && modeActive && (&wrBe) && ((wrSel == 2'd0) || (wrSel == 2'd2));

  // Independent model of the remaining burst length
  always_ff @(posedge clk) begin
    if (!rstN)               expRem <= '0;
    else if (fwdLow)         expRem <= (clkPerWrite == '0) ? CNT_W'(1) : clkPerWrite;
    else if (expRem != '0)   expRem <= expRem - CNT_W'(1);
  end

  assert_fwd_word_R1: assert property (@(posedge clk) disable iff (!rstN)
    (acc && modeActive && (&wrBe) && wrSel == 2'd0) |=>
      (cfgClkEn && cfgData[WORD_W-1:0] == $past(wrData)));

  assert_burst_len_R2: assert property (@(posedge clk) disable iff (!rstN)
    cfgClkEn == (expRem != '0));

  assert_partial_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (acc && !busy && (!(&wrBe) || wrSel == 2'd3)) |=> (!cfgClkEn && $stable(cfgData)));

  assert_upper_no_burst_R4: assert property (@(posedge clk) disable iff (!rstN)
    (acc && !busy && wrSel == 2'd1) |=> (!cfgClkEn && $stable(cfgData)));

  assert_mem_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    (acc && modeActive && (&wrBe) && wrSel == 2'd2) |=>
      (cfgClkEn && cfgData[WORD_W-1:0] == $past(wrData)));

  assert_inactive_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (acc && !modeActive && !busy) |=> (!cfgClkEn && $stable(cfgData)));

  assert_ready_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> wrReady);

  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !wrReady) |=> busy);

endmodule

bind cfg_burst_fwd cfg_burst_fwd_chk #(
  .WORD_W(WORD_W), .CNT_W(CNT_W), .BE_W(BE_W), .OUT_W(OUT_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .modeActive (modeActive),
  .wrValid    (wrValid),
  .wrReady    (wrReady),
  .wrSel      (wrSel),
  .wrBe       (wrBe),
  .wrData     (wrData),
  .clkPerWrite(clkPerWrite),
  .cfgData    (cfgData),
  .cfgClkEn   (cfgClkEn),
  .busy       (busy)
);

// File: tb/sim_cfg_burst_fwd.sv
`timescale 1ns/1ps
module sim_cfg_burst_fwd;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeActive = 1'b0;
  logic        wrValid = 1'b0;
  logic        wrReady;
  logic [1:0]  wrSel = 2'd0;
  logic [3:0]  wrBe = 4'h0;
  logic [31:0] wrData = '0;
  logic [7:0]  clkPerWrite = 8'd1;
  logic [63:0] cfgData;
  logic        cfgClkEn;
  logic        busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cfg_burst_fwd u0 (
    .clk(clk), .rstN(rstN), .modeActive(modeActive), .wrValid(wrValid),
    .wrReady(wrReady), .wrSel(wrSel), .wrBe(wrBe), .wrData(wrData),
    .clkPerWrite(clkPerWrite), .cfgData(cfgData), .cfgClkEn(cfgClkEn), .busy(busy)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic [3:0]  be;
    logic [31:0] data;
    logic [7:0]  setN;
    logic        mode;
    int          expCnt;
    int          req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'hF, 32'h1111_1111, 8'd1, 1'b1, 1, 1}, // R1 plain image
    '{2'd0, 4'hF, 32'h2222_2222, 8'd4, 1'b1, 4, 2}, // R2 encrypted
    '{2'd0, 4'hF, 32'h3333_3333, 8'd8, 1'b1, 8, 2}, // R2 compressed
    '{2'd0, 4'hF, 32'h4444_4444, 8'd0, 1'b1, 1, 2}, // R2 zero setting
    '{2'd1, 4'hF, 32'hAAAA_0001, 8'd4, 1'b1, 0, 4}, // R4 upper staging
    '{2'd0, 4'hF, 32'h5555_5555, 8'd4, 1'b1, 4, 4}, // R4 wide word
    '{2'd2, 4'hF, 32'h6666_6666, 8'd8, 1'b1, 8, 5}, // R5 memory window
    '{2'd0, 4'h7, 32'h7777_7777, 8'd4, 1'b1, 0, 3}, // R3 partial enables
    '{2'd3, 4'hF, 32'h8888_8888, 8'd4, 1'b1, 0, 3}, // R3 unrelated register
    '{2'd0, 4'hF, 32'h9999_9999, 8'd4, 1'b0, 0, 6}, // R6 mode inactive
    '{2'd2, 4'hF, 32'hBBBB_BBBB, 8'd8, 1'b0, 0, 6}, // R6 window, mode inactive
    '{2'd1, 4'hE, 32'hCCCC_CCCC, 8'd4, 1'b1, 0, 3}, // R3 partial upper write
    '{2'd1, 4'hF, 32'hDDDD_DDDD, 8'd4, 1'b0, 0, 6}, // R6 upper, mode inactive
    '{2'd0, 4'hF, 32'hEEEE_EEEE, 8'd3, 1'b1, 3, 4}  // R4 staged half retained
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive one write, wait for acceptance; returns at the negedge after the accepting edge
  task automatic doWrite(input logic [1:0] s, input logic [3:0] b, input logic [31:0] d,
                         input logic [7:0] n, input logic m);
    wrSel = s; wrBe = b; wrData = d; clkPerWrite = n; modeActive = m; wrValid = 1'b1;
    while (!wrReady) @(negedge clk);
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] expUpper;
    logic [63:0] expWord;
    int          n;
    string       tag;

    repeat (3) @(negedge clk);
    // R8 reset state
    check(cfgClkEn == 1'b0 && busy == 1'b0, "R8", "reset clken/busy", {cfgClkEn, busy}, 0);
    check(wrReady == 1'b1, "R8", "reset ready", wrReady, 1);
    check(cfgData == 64'd0, "R8", "reset data", cfgData, 0);
    rstN = 1'b1;
    @(negedge clk);

    expUpper = '0;
    expWord  = '0;
    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      bit fullOk = (v.be == 4'hF) && v.mode;
      tag = $sformatf("R%0d", v.req);
      doWrite(v.sel, v.be, v.data, v.setN, v.mode);
      if (fullOk && (v.sel == 2'd0 || v.sel == 2'd2)) expWord = {expUpper, v.data};
      if (fullOk && v.sel == 2'd1) expUpper = v.data;
      n = 0;
      for (int k = 0; k < 300 && cfgClkEn; k++) begin
        n++;
        @(negedge clk);
      end
      check(n == v.expCnt, tag, $sformatf("vector %0d burst length", i), n, v.expCnt);
      check(cfgData == expWord, tag, $sformatf("vector %0d word", i), cfgData, expWord);
    end

    // R7 and R9: a write stalled behind a burst chains into it
    begin
      int cnt = 0, first = -1, last = -1;
      bit drop = 1'b0, stallSeen = 1'b0;
      doWrite(2'd0, 4'hF, 32'h0102_0304, 8'd8, 1'b1);
      wrSel = 2'd2; wrBe = 4'hF; wrData = 32'hA5A5_5A5A; clkPerWrite = 8'd2; wrValid = 1'b1;
      for (int k = 1; k <= 20; k++) begin
        if (cfgClkEn) begin
          cnt++;
          if (first < 0) first = k;
          last = k;
        end
        if (k == 1) stallSeen = !wrReady && busy;
        if (drop) begin wrValid = 1'b0; drop = 1'b0; end
        if (wrValid && wrReady) drop = 1'b1;
        @(negedge clk);
      end
      check(stallSeen, "R7", "stall while busy", stallSeen, 1);
      check(cnt == 10, "R7", "stalled write forwarded, total enables", cnt, 10);
      check((last - first + 1) == cnt, "R9", "no gap between bursts", last - first + 1, cnt);
      check(cfgData == {expUpper, 32'hA5A5_5A5A}, "R7", "stalled word", cfgData,
            {expUpper, 32'hA5A5_5A5A});
    end

    // R8 reset in the middle of a burst
    doWrite(2'd0, 4'hF, 32'hFACE_0000, 8'd8, 1'b1);
    check(busy == 1'b1, "R7", "busy during burst", busy, 1);
    rstN = 1'b0;
    @(negedge clk);
    check(!cfgClkEn && !busy && wrReady, "R8", "mid-burst reset idle",
          {cfgClkEn, busy, wrReady}, 3'b001);
    check(cfgData == 64'd0, "R8", "mid-burst reset data", cfgData, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R8: staging half cleared by reset
    doWrite(2'd0, 4'hF, 32'h0000_0042, 8'd1, 1'b1);
    check(cfgData == 64'h0000_0000_0000_0042, "R8", "upper cleared by reset", cfgData,
          64'h42);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule